// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block fans software-raised interrupts from several CPUs out to their targets and keeps track of who raised them. Each CPU owns a 32-bit trigger port. A trigger word names one of sixteen software interrupt numbers, a target-selection mode and an explicit target list. For every CPU that the word selects, the block records the writer's number in a per-target, per-interrupt source vector. An interrupt counts as pending for a CPU whenever that vector holds at least one bit.

Each CPU retires its software interrupts through an acknowledge port. Every acknowledge is handled by a small per-CPU state machine with two states. ACK_IDLE accepts a request. The transition ACCEPT moves it to ACK_REPLY, and in the same edge it removes the lowest-numbered source bit from the requested vector. ACK_REPLY presents the reply word for one cycle. The transition RETIRE returns it to ACK_IDLE. The reply word combines the interrupt number with the serviced source CPU. A separate byte-wide port lets system code set or clear source bits of one vector directly, and a read port shows any vector.

Several writers may trigger in the same cycle. An acknowledge, a trigger and a direct write can all land on the same vector together, and each of them takes effect.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source vector is zero, `pend` is all zero, every `ack_ready` bit is 1 and every `ack_valid` bit is 0.
- R2: A trigger word carries the interrupt number in bits [9:0], the target list in bits [23:16] (bit n selects CPU n) and the mode in bits [25:24]. Mode 0 sends to the CPUs in the list, and list bits at or above NCPU are ignored.
- R3: Mode 1 sends to every CPU except the writer. Mode 2 sends to the writer only. Mode 3 sends to all CPUs.
- R4: For every selected target t, bit w (the writer's number) is set in the vector of target t for that interrupt, one cycle after the trigger. `pend[t*16+id]` is 1 exactly when that vector is nonzero.
- R5: A trigger whose number is 16 or above changes no vector.
- R6: Triggers from several writers in the same cycle are all recorded. Their source bits merge without loss.
- R7: An accepted acknowledge for interrupt id clears the lowest set source bit s of that vector. In the next cycle `ack_valid` is high for exactly one cycle, with `ack_word` = id | (s << 10). The interrupt stays pending until its vector is empty.
- R8: An acknowledge of an empty vector replies 1023 and changes no vector.
- R9: A direct write with set=1 ORs the byte (bit n = source CPU n) into one vector. With set=0 it removes the written bits. Byte bits at or above NCPU are ignored.
- R10: During the reply cycle `ack_ready` is 0, and an acknowledge request in that cycle is dropped. It produces no reply and changes no vector.
- R11: When an acknowledge and a trigger hit the same vector in one cycle, the reply is computed from the old vector, and a source bit set by the trigger survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | NCPU | Trigger strobe, one bit per writing CPU |
| trig_word | input | NCPU*32 | Trigger words, CPU n in bits [n*32 +: 32] |
| ack_req | input | NCPU | Acknowledge request per CPU |
| ack_id | input | NCPU*4 | Interrupt number to acknowledge, CPU n in [n*4 +: 4] |
| ack_ready | output | NCPU | Acknowledge state machine in ACK_IDLE |
| ack_valid | output | NCPU | Reply word valid (ACK_REPLY) |
| ack_word | output | NCPU*13 | Reply words, CPU n in [n*13 +: 13] |
| srcw_valid | input | 1 | Direct source-byte write strobe |
| srcw_set | input | 1 | 1 = OR bits in, 0 = clear bits |
| srcw_cpu | input | CPU_W | Target CPU of the direct write |
| srcw_id | input | 4 | Interrupt number of the direct write |
| srcw_bits | input | 8 | Source bits, bit n = source CPU n |
| rd_cpu | input | CPU_W | Read port CPU select |
| rd_id | input | 4 | Read port interrupt select |
| rd_src | output | NCPU | Selected source vector (combinational) |
| pend | output | NCPU*16 | Pending flag, CPU t interrupt i at bit t*16+i |

## Verification
Each target mode is driven from a different writer, so that a mode decoded wrongly, or a writer number put in the wrong bit, shows up as a wrong vector rather than a coincidentally correct one. An explicit list with bits above the CPU count, and trigger numbers just past the valid range, separate correct masking from raw pass-through. A four-writer same-cycle trigger followed by four acknowledges tests merging and the lowest-first retirement order, and pending has to persist until the last one. A busy-cycle acknowledge, an empty-vector acknowledge, a same-cycle acknowledge plus trigger, and direct byte set and clear with out-of-range bits cover the edge cases of the reply state machine and the vector update order.

// File: rtl/sgi_pkg.sv
`timescale 1ns/1ps
package sgi_pkg;
    localparam int SGI_COUNT   = 16;
    localparam int SGI_ID_W    = 4;
    localparam int TRIG_W      = 32;
    localparam int TRIG_ID_W   = 10;
    localparam int SRC_FIELD_W = 3;
    localparam int ACK_W       = TRIG_ID_W + SRC_FIELD_W;
    localparam int BYTE_W      = 8;
    localparam logic [TRIG_ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } filter_e;

    typedef enum logic {
        ACK_IDLE  = 1'b0,
        ACK_REPLY = 1'b1
    } ack_state_e;
endpackage

// File: rtl/sgi_trig_decode.sv
`timescale 1ns/1ps
module sgi_trig_decode
    import sgi_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int WRITER = 0
) (
    input  logic                 valid,
    input  logic [TRIG_W-1:0]    word,
    output logic                 hit,
    output logic [SGI_ID_W-1:0]  id,
    output logic [NCPU-1:0]      targets
);
    localparam logic [NCPU-1:0] ALL_MASK  = {NCPU{1'b1}};
    localparam logic [NCPU-1:0] SELF_MASK = NCPU'(1) << WRITER;

    filter_e mode;
    logic    unused_word_bits;

    assign unused_word_bits = ^word;
    assign mode = filter_e'(word[25:24]);
    assign id   = word[SGI_ID_W-1:0];
    assign hit  = valid && (word[TRIG_ID_W-1:SGI_ID_W] == '0);

    always_comb begin
        unique case (mode)
            FLT_LIST:   targets = word[16 +: NCPU];
            FLT_OTHERS: targets = ALL_MASK & ~SELF_MASK;
            FLT_SELF:   targets = SELF_MASK;
            FLT_ALL:    targets = ALL_MASK;
        endcase
    end
endmodule

// File: rtl/sgi_ack_fsm.sv
`timescale 1ns/1ps
module sgi_ack_fsm
    import sgi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [SGI_ID_W-1:0]         req_id,
    input  logic [SGI_COUNT*NCPU-1:0]   vec_flat,
    output logic                        ready,
    output logic                        valid,
    output logic [ACK_W-1:0]            word,
    output logic [SGI_ID_W-1:0]         clr_id,
    output logic [NCPU-1:0]             clr_mask
);
    ack_state_e state, state_nxt;
    logic [NCPU-1:0]        sel_vec;
    logic [SRC_FIELD_W-1:0] low_idx;
    logic                   low_found;
    logic                   accept;
    logic [ACK_W-1:0]       word_nxt, word_q;

    // lowest-numbered source in the requested vector
    always_comb begin
        sel_vec   = vec_flat[int'(req_id)*NCPU +: NCPU];
        low_idx   = '0;
        low_found = 1'b0;
        for (int b = NCPU - 1; b >= 0; b--) begin
            if (sel_vec[b]) begin
                low_idx   = SRC_FIELD_W'(b);
                low_found = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= state_nxt;
    end

    // transitions: ACCEPT (IDLE->REPLY), RETIRE (REPLY->IDLE)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ACK_IDLE:  if (req) state_nxt = ACK_REPLY;
            ACK_REPLY: state_nxt = ACK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = 1'b0;
        valid    = 1'b0;
        accept   = 1'b0;
        clr_mask = '0;
        clr_id   = req_id;
        word_nxt = {{SRC_FIELD_W{1'b0}}, SPURIOUS_ID};
        unique case (state)
            ACK_IDLE: begin
                ready  = 1'b1;
                accept = req;
                if (low_found) begin
                    word_nxt = {low_idx, {(TRIG_ID_W-SGI_ID_W){1'b0}}, req_id};
                    if (req) clr_mask = NCPU'(1) << low_idx;
                end
            end
            ACK_REPLY: valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (accept) word_q <= word_nxt;
    end

    assign word = word_q;
endmodule

// File: rtl/sgi_src_matrix.sv
`timescale 1ns/1ps
module sgi_src_matrix
    import sgi_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCPU-1:0]                   trig_hit,
    input  logic [NCPU*SGI_ID_W-1:0]          trig_id,
    input  logic [NCPU*NCPU-1:0]              trig_tgt,
    input  logic [NCPU*SGI_ID_W-1:0]          clr_id,
    input  logic [NCPU*NCPU-1:0]              clr_mask,
    input  logic                              srcw_valid,
    input  logic                              srcw_set,
    input  logic [CPU_W-1:0]                  srcw_cpu,
    input  logic [SGI_ID_W-1:0]               srcw_id,
    input  logic [BYTE_W-1:0]                 srcw_bits,
    output logic [NCPU*SGI_COUNT*NCPU-1:0]    src_flat
);
    logic unused_byte_bits;
    assign unused_byte_bits = ^srcw_bits;

    for (genvar t = 0; t < NCPU; t++) begin : g_tgt
        for (genvar s = 0; s < SGI_COUNT; s++) begin : g_sgi
            localparam logic [CPU_W-1:0]    T_IDX = CPU_W'(t);
            localparam logic [SGI_ID_W-1:0] S_IDX = SGI_ID_W'(s);
            logic [NCPU-1:0] vec, set_bits, clr_bits;
            logic            here;

            assign here = srcw_valid && (srcw_cpu == T_IDX) && (srcw_id == S_IDX);

            always_comb begin
                set_bits = '0;
                for (int w = 0; w < NCPU; w++) begin
                    if (trig_hit[w] && (trig_id[w*SGI_ID_W +: SGI_ID_W] == S_IDX)
                        && trig_tgt[w*NCPU + t])
                        set_bits[w] = 1'b1;
                end
                if (here && srcw_set) set_bits = set_bits | srcw_bits[NCPU-1:0];
                clr_bits = (clr_id[t*SGI_ID_W +: SGI_ID_W] == S_IDX)
                         ? clr_mask[t*NCPU +: NCPU] : '0;
                if (here && !srcw_set) clr_bits = clr_bits | srcw_bits[NCPU-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vec <= '0;
                else        vec <= (vec & ~clr_bits) | set_bits;
            end

            assign src_flat[(t*SGI_COUNT + s)*NCPU +: NCPU] = vec;
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
`timescale 1ns/1ps
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter  int NCPU  = 4,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCPU-1:0]             trig_valid,
    input  logic [NCPU*TRIG_W-1:0]      trig_word,
    input  logic [NCPU-1:0]             ack_req,
    input  logic [NCPU*SGI_ID_W-1:0]    ack_id,
    output logic [NCPU-1:0]             ack_ready,
    output logic [NCPU-1:0]             ack_valid,
    output logic [NCPU*ACK_W-1:0]       ack_word,
    input  logic                        srcw_valid,
    input  logic                        srcw_set,
    input  logic [CPU_W-1:0]            srcw_cpu,
    input  logic [SGI_ID_W-1:0]         srcw_id,
    input  logic [BYTE_W-1:0]           srcw_bits,
    input  logic [CPU_W-1:0]            rd_cpu,
    input  logic [SGI_ID_W-1:0]         rd_id,
    output logic [NCPU-1:0]             rd_src,
    output logic [NCPU*SGI_COUNT-1:0]   pend
);
    localparam int VEC_PER_CPU = SGI_COUNT * NCPU;

    logic [NCPU-1:0]                  trig_hit;
    logic [NCPU*SGI_ID_W-1:0]         trig_id;
    logic [NCPU*NCPU-1:0]             trig_tgt;
    logic [NCPU*SGI_ID_W-1:0]         clr_id;
    logic [NCPU*NCPU-1:0]             clr_mask;
    logic [NCPU*VEC_PER_CPU-1:0]      src_flat;

    for (genvar w = 0; w < NCPU; w++) begin : g_dec
        sgi_trig_decode #(.NCPU(NCPU), .WRITER(w)) u_dec (
            .valid   (trig_valid[w]),
            .word    (trig_word[w*TRIG_W +: TRIG_W]),
            .hit     (trig_hit[w]),
            .id      (trig_id[w*SGI_ID_W +: SGI_ID_W]),
            .targets (trig_tgt[w*NCPU +: NCPU])
        );
    end

    sgi_src_matrix #(.NCPU(NCPU), .CPU_W(CPU_W)) u_mat (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_hit   (trig_hit),
        .trig_id    (trig_id),
        .trig_tgt   (trig_tgt),
        .clr_id     (clr_id),
        .clr_mask   (clr_mask),
        .srcw_valid (srcw_valid),
        .srcw_set   (srcw_set),
        .srcw_cpu   (srcw_cpu),
        .srcw_id    (srcw_id),
        .srcw_bits  (srcw_bits),
        .src_flat   (src_flat)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_ack
        sgi_ack_fsm #(.NCPU(NCPU)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (ack_req[c]),
            .req_id   (ack_id[c*SGI_ID_W +: SGI_ID_W]),
            .vec_flat (src_flat[c*VEC_PER_CPU +: VEC_PER_CPU]),
            .ready    (ack_ready[c]),
            .valid    (ack_valid[c]),
            .word     (ack_word[c*ACK_W +: ACK_W]),
            .clr_id   (clr_id[c*SGI_ID_W +: SGI_ID_W]),
            .clr_mask (clr_mask[c*NCPU +: NCPU])
        );
        for (genvar s = 0; s < SGI_COUNT; s++) begin : g_pend
            assign pend[c*SGI_COUNT + s] = |src_flat[(c*SGI_COUNT + s)*NCPU +: NCPU];
        end
    end

    always_comb begin
        rd_src = '0;
        if (int'(rd_cpu) < NCPU)
            rd_src = src_flat[(int'(rd_cpu)*SGI_COUNT + int'(rd_id))*NCPU +: NCPU];
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
`timescale 1ns/1ps
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NCPU-1:0]             trig_valid,
    input logic [NCPU*TRIG_W-1:0]      trig_word,
    input logic [NCPU-1:0]             ack_req,
    input logic [NCPU-1:0]             ack_ready,
    input logic [NCPU-1:0]             ack_valid,
    input logic [NCPU*ACK_W-1:0]       ack_word,
    input logic                        srcw_valid,
    input logic [NCPU*SGI_COUNT-1:0]   pend
);
    logic unused_trig_bits;
    assign unused_trig_bits = ^trig_word;

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        // R7: a reply lasts exactly one cycle
        a_r7_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
            ack_valid[c] |=> !ack_valid[c]);

        // R10: an accepted request is answered in the next cycle
        a_r10_reply_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_ready[c] && ack_req[c]) |=> ack_valid[c]);

        // R7: a non-spurious reply names a valid interrupt and a real source CPU
        a_r7_reply_fields: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid[c] && ack_word[c*ACK_W +: TRIG_ID_W] != SPURIOUS_ID) |->
            (ack_word[c*ACK_W +: TRIG_ID_W] < TRIG_ID_W'(SGI_COUNT)
             && int'(ack_word[c*ACK_W + TRIG_ID_W +: SRC_FIELD_W]) < NCPU));

        // R3: a self-targeted trigger leaves the writer pending
        a_r3_self_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_valid[c] && trig_word[c*TRIG_W + SGI_ID_W +: 6] == '0
             && trig_word[c*TRIG_W + 24 +: 2] == 2'd2) |=>
            pend[c*SGI_COUNT + int'($past(trig_word[c*TRIG_W +: SGI_ID_W]))]);
    end

    // R4: without any stimulus the pending flags hold
    a_r4_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid == '0 && !srcw_valid && (ack_req & ack_ready) == '0) |=> $stable(pend));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    trig_valid = '0;
    logic [N*32-1:0] trig_word = '0;
    logic [N-1:0]    ack_req = '0;
    logic [N*4-1:0]  ack_id = '0;
    logic [N-1:0]    ack_ready, ack_valid;
    logic [N*13-1:0] ack_word;
    logic            srcw_valid = 1'b0, srcw_set = 1'b0;
    logic [1:0]      srcw_cpu = '0;
    logic [3:0]      srcw_id = '0;
    logic [7:0]      srcw_bits = '0;
    logic [1:0]      rd_cpu = '0;
    logic [3:0]      rd_id = '0;
    logic [N-1:0]    rd_src;
    logic [N*16-1:0] pend;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  m [N][16];
    logic [15:0] sb_q [$];

    always #10 clk = ~clk;

    sgi_dispatch #(.NCPU(N)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int id, input logic [7:0] list, input logic [1:0] flt);
        return {6'b0, flt, list, 6'b0, 10'(id)};
    endfunction

    function automatic logic [3:0] tgts(input int w, input logic [31:0] wd);
        case (wd[25:24])
            2'd0: return wd[19:16];
            2'd1: return 4'hF & ~(4'(1) << w);
            2'd2: return 4'(1) << w;
            default: return 4'hF;
        endcase
    endfunction

    // compare pending flags and every source vector with the model
    task automatic check_state(input string req);
        logic [N*16-1:0] ep;
        bit ok;
        logic [3:0] bad_a, bad_e;
        ok = 1'b1; bad_a = '0; bad_e = '0;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < 16; s++) ep[t*16+s] = |m[t][s];
        chk(pend == ep, {req, " pending"}, pend, ep);
        for (int t = 0; t < N; t++)
            for (int s = 0; s < 16; s++) begin
                rd_cpu = 2'(t); rd_id = 4'(s);
                #0.1;
                if (ok && rd_src != m[t][s]) begin
                    ok = 1'b0; bad_a = rd_src; bad_e = m[t][s];
                end
            end
        chk(ok, {req, " vectors"}, bad_a, bad_e);
    endtask

    // one cycle of stimulus: triggers (mask tv) plus an optional acknowledge
    task automatic step(input logic [N-1:0] tv, input logic [N*32-1:0] tw,
                        input int ac, input int aid);
        @(negedge clk);
        if (ac >= 0) begin
            logic [3:0] v;
            logic [12:0] ew;
            v = m[ac][aid];
            ew = {3'b0, 10'd1023};
            for (int b = N - 1; b >= 0; b--)
                if (v[b]) ew = {3'(b), 6'b0, 4'(aid)};
            if (v != 0) m[ac][aid][ew[12:10]] = 1'b0;
            sb_q.push_back({3'(ac), ew});
            ack_req[ac] = 1'b1;
            ack_id[ac*4 +: 4] = 4'(aid);
        end
        for (int w = 0; w < N; w++)
            if (tv[w] && tw[w*32+4 +: 6] == 0)
                for (int t = 0; t < N; t++)
                    if (tgts(w, tw[w*32 +: 32])[t]) m[t][tw[w*32 +: 4]][w] = 1'b1;
        trig_valid = tv;
        trig_word = tw;
        @(negedge clk);
        trig_valid = '0;
        ack_req = '0;
    endtask

    task automatic trig1(input int w, input logic [31:0] wd);
        logic [N*32-1:0] tw;
        tw = '0;
        tw[w*32 +: 32] = wd;
        step(4'(1) << w, tw, -1, 0);
    endtask

    task automatic ack1(input int c, input int id);
        step('0, '0, c, id);
        @(negedge clk);
    endtask

    task automatic srcw(input bit set, input int cpu, input int id, input logic [7:0] bits);
        @(negedge clk);
        srcw_valid = 1'b1; srcw_set = set; srcw_cpu = 2'(cpu); srcw_id = 4'(id); srcw_bits = bits;
        for (int b = 0; b < N; b++)
            if (bits[b]) m[cpu][id][b] = set;
        @(negedge clk);
        srcw_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (rst_n && ack_valid[c]) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected reply", {c[2:0], ack_word[c*13 +: 13]}, 0);
                end else begin
                    logic [15:0] e;
                    e = sb_q.pop_front();
                    chk(e == {3'(c), ack_word[c*13 +: 13]}, "R7 reply word",
                        {3'(c), ack_word[c*13 +: 13]}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [N*32-1:0] tw;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < 16; s++) m[t][s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pend == '0, "R1 pend", pend, 0);
        chk(ack_ready == 4'hF && ack_valid == '0, "R1 handshake", {ack_ready, ack_valid}, 8'hF0);
        check_state("R1");

        trig1(1, mk(3, 8'b0101, 2'd0));      // R2 list
        check_state("R2 R4 list mode");
        trig1(2, mk(5, 8'h00, 2'd1));        // R3 others
        check_state("R3 others mode");
        trig1(3, mk(7, 8'hFF, 2'd2));        // R3 self
        check_state("R3 self mode");
        trig1(0, mk(9, 8'h00, 2'd3));        // R3 all
        check_state("R3 all mode");
        trig1(0, mk(2, 8'hF2, 2'd0));        // R2 high list bits ignored
        check_state("R2 list masking");
        trig1(1, mk(16, 8'hFF, 2'd3));       // R5
        trig1(2, mk(10'h203, 8'hFF, 2'd3));  // R5
        check_state("R5 out of range id");

        // R6 four writers at once
        tw = {mk(12, 8'h08, 2'd0), mk(12, 8'h08, 2'd0), mk(12, 8'h08, 2'd0), mk(12, 8'h08, 2'd0)};
        step(4'hF, tw, -1, 0);
        check_state("R6 merge");

        // R7 retire sources lowest first
        for (int k = 0; k < 4; k++) begin
            ack1(3, 12);
            check_state("R7 ack sequence");
        end
        // R8 empty vector
        ack1(1, 15);
        check_state("R8 spurious");

        // R10 request during reply is dropped
        step('0, '0, 2, 3);
        chk(ack_ready[2] == 1'b0, "R10 busy", ack_ready[2], 0);
        ack_req[2] = 1'b1; ack_id[8 +: 4] = 4'd3;
        @(negedge clk);
        ack_req = '0;
        chk(ack_valid[2] == 1'b0, "R10 no second reply", ack_valid[2], 0);
        check_state("R10 dropped request");

        // R9 direct byte writes
        srcw(1'b1, 2, 4, 8'hFA);
        check_state("R9 set");
        srcw(1'b0, 2, 4, 8'h02);
        check_state("R9 clear");

        // R11 acknowledge and trigger on one vector
        tw = '0;
        tw[31:0] = mk(9, 8'h00, 2'd2);
        step(4'b0001, tw, 0, 9);
        @(negedge clk);
        check_state("R11 ack with trigger");

        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule